// File: doc/BRIEF.md
# UART Transmit Holding FIFO

This block holds the characters that a processor has queued for a UART transmitter. A write strobe loads 8-bit characters. A serializer drains them through a valid/pop handshake, and it pops a character only when its shift register is free. The block has two modes. In single-register mode it keeps one character. In queue mode it keeps up to 64 characters and sends them out in the order they were written.

The block drives a transmit-data-request flag that tells software whether it can load more data. In single-register mode the flag shows whether the holding register is free. In queue mode the flag follows the fill level around the half-way point, with a dead band exactly at half. An interrupt request is the flag gated by an enable input. The mode select and the interrupt enable are plain inputs. Changing the mode discards everything that is buffered.

Top module: `uart_tx_buffer`

## Requirements
- R1: After reset the buffer is empty (`tx_valid`=0), `tdrq`=1, and the block starts in single-register mode.
- R2: In queue mode, characters leave in the order they were written. `tx_valid` is 1 whenever at least one character is queued, and `tx_data` shows the oldest queued character.
- R3: Queue capacity is 64. A write made while 64 characters are queued, with no pop in the same cycle, is discarded.
- R4: In queue mode, a write and a pop in the same cycle on a full queue both take effect, and the occupancy stays at 64.
- R5: In queue mode, `tdrq` is 1 when occupancy is below 32 and 0 when occupancy is above 32. At exactly 32 it keeps its previous value. The flag is updated together with the occupancy, in the cycle after the write or pop.
- R6: In single-register mode, a write loads the holding register and clears `tdrq` on the next cycle. A write to an occupied register replaces the character. A pop of an occupied register empties it and sets `tdrq`. A write and a pop in the same cycle send out the old character, keep the new one and leave `tdrq`=0.
- R7: `irq` is 1 exactly when `tdrq`=1 and `req_ie`=1.
- R8: A change of `fifo_mode` is applied on the next clock edge. That edge empties the queue and the holding register and sets `tdrq`=1, and any write or pop in that cycle is ignored.
- R9: A pop while `tx_valid`=0 has no effect: nothing leaves the buffer and `tdrq` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_mode | input | 1 | 1 = 64-entry queue mode, 0 = single-register mode |
| req_ie | input | 1 | Enable for the transmit-request interrupt |
| wr_en | input | 1 | Processor write strobe |
| wr_data | input | 8 | Character to write |
| pop | input | 1 | Serializer takes the presented character |
| tx_valid | output | 1 | A character is available to the serializer |
| tx_data | output | 8 | Oldest buffered character |
| tdrq | output | 1 | Transmit data request flag |
| irq | output | 1 | Gated interrupt request |

## Verification
Directed sequences cover three cases. The first fills the queue one character at a time across 31, 32 and 33 entries and then drains it, which separates the hysteresis at exactly half from a plain threshold. The second writes past 64 and then does a write and a pop together on a full queue, which tells a dropped write apart from an overwrite or a lost pop. The third exercises the single-register corner cases: overwrite, write together with pop, and pop while empty. After these, a random phase alternates a write-heavy bias with a pop-heavy bias, so occupancy sweeps back and forth across the threshold. That phase also switches mode occasionally while data is queued, and toggles the interrupt enable, so flushing and the gating are seen from many different states.

// File: rtl/uart_tx_buffer.sv
module uart_tx_buffer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              req_ie,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tdrq,
  output logic              irq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int HALF  = DEPTH / 2;

  logic              mode_q;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count, count_nx;
  logic [DATA_W-1:0] hold_data;
  logic              hold_full;
  logic              tdrq_q, tdrq_nx;

  wire mode_chg = fifo_mode ^ mode_q;
  wire f_act    = mode_q & ~mode_chg;
  wire n_act    = ~mode_q & ~mode_chg;
  wire f_pop    = f_act & pop & (count != '0);
  wire f_push   = f_act & wr_en & ((count != CNT_W'(DEPTH)) | f_pop);
  wire n_wr     = n_act & wr_en;
  wire n_pop    = n_act & pop & hold_full;

  assign count_nx = count + CNT_W'(f_push) - CNT_W'(f_pop);

  always_comb begin
    tdrq_nx = tdrq_q;
    if (mode_chg)                      tdrq_nx = 1'b1;
    else if (mode_q) begin
      if (count_nx < CNT_W'(HALF))     tdrq_nx = 1'b1;
      else if (count_nx > CNT_W'(HALF)) tdrq_nx = 1'b0;
    end else begin
      if (n_wr)                        tdrq_nx = 1'b0;
      else if (n_pop)                  tdrq_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      hold_data <= '0;
      hold_full <= 1'b0;
      tdrq_q    <= 1'b1;
    end else begin
      mode_q <= fifo_mode;
      tdrq_q <= tdrq_nx;
      if (mode_chg) begin
        wr_ptr    <= '0;
        rd_ptr    <= '0;
        count     <= '0;
        hold_full <= 1'b0;
      end else begin
        if (f_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
        if (f_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
        count <= count_nx;
        if (n_wr) begin
          hold_data <= wr_data;
          hold_full <= 1'b1;
        end else if (n_pop) begin
          hold_full <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (f_push) mem[wr_ptr] <= wr_data;

  assign tx_valid = mode_q ? (count != '0) : hold_full;
  assign tx_data  = mode_q ? mem[rd_ptr] : hold_data;
  assign tdrq     = tdrq_q;
  assign irq      = tdrq_q & req_ie;
endmodule

// File: rtl/uart_tx_buffer_chk.sv
module uart_tx_buffer_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_mode,
  input logic             mode_q,
  input logic             wr_en,
  input logic             pop,
  input logic             req_ie,
  input logic             tx_valid,
  input logic             tdrq,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic             hold_full
);
  localparam int HALF = DEPTH / 2;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && fifo_mode && count == CNT_W'(DEPTH) && wr_en && !pop) |=> count == CNT_W'(DEPTH)); // R3
  AST_FULL_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && fifo_mode && count == CNT_W'(DEPTH) && wr_en && pop) |=> (count == CNT_W'(DEPTH) && tx_valid)); // R4
  AST_FLAG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && count < CNT_W'(HALF)) |-> tdrq); // R5
  AST_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && count > CNT_W'(HALF)) |-> !tdrq); // R5
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !fifo_mode && wr_en) |=> (!tdrq && tx_valid)); // R6
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tdrq && req_ie)); // R7
  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode != mode_q) |=> (count == '0 && !hold_full && tdrq && !tx_valid)); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && pop && !wr_en && fifo_mode == mode_q) |=> ($stable(count) && $stable(hold_full) && $stable(tdrq))); // R9
endmodule

bind uart_tx_buffer uart_tx_buffer_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .mode_q(mode_q),
  .wr_en(wr_en), .pop(pop), .req_ie(req_ie), .tx_valid(tx_valid),
  .tdrq(tdrq), .irq(irq), .count(count), .hold_full(hold_full)
);

// File: tb/uart_tx_buffer_bench.sv
module uart_tx_buffer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_mode = 1'b0, req_ie = 1'b0, wr_en = 1'b0, pop = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_valid, tdrq, irq;
  logic [7:0] tx_data;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_q [$];
  logic       m_mode = 1'b0, m_hold_v = 1'b0, m_tdrq = 1'b1;
  logic [7:0] m_hold = '0;

  always #4 clk = ~clk;

  uart_tx_buffer u_uart_tx_buffer (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .req_ie(req_ie),
    .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
    .tx_valid(tx_valid), .tx_data(tx_data), .tdrq(tdrq), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_valid();
    return m_mode ? (m_q.size() != 0) : m_hold_v;
  endfunction

  function automatic logic [7:0] exp_data();
    return m_mode ? m_q[0] : m_hold;
  endfunction

  task automatic model_edge(input logic w, input logic [7:0] d, input logic p);
    if (fifo_mode != m_mode) begin
      m_q.delete();
      m_hold_v = 1'b0;
      m_mode = fifo_mode;
      m_tdrq = 1'b1;
    end else if (m_mode) begin
      if (p && m_q.size() != 0) void'(m_q.pop_front());
      if (w && m_q.size() < 64) m_q.push_back(d);
      if (m_q.size() < 32) m_tdrq = 1'b1;
      else if (m_q.size() > 32) m_tdrq = 1'b0;
    end else begin
      if (p && m_hold_v) begin m_hold_v = 1'b0; m_tdrq = 1'b1; end
      if (w) begin m_hold = d; m_hold_v = 1'b1; m_tdrq = 1'b0; end
    end
  endtask

  task automatic compare_all();
    chk(m_mode ? "R2 tx_valid" : "R6 tx_valid", tx_valid, exp_valid());
    if (exp_valid()) chk(m_mode ? "R2 tx_data" : "R6 tx_data", tx_data, exp_data());
    chk(m_mode ? "R5 tdrq" : "R6 tdrq", tdrq, m_tdrq);
    chk("R7 irq", irq, m_tdrq & req_ie);
  endtask

  task automatic cyc(input logic w, input logic [7:0] d, input logic p);
    wr_en = w; wr_data = d; pop = p;
    @(posedge clk);
    model_edge(w, d, p);
    @(negedge clk);
    wr_en = 1'b0; pop = 1'b0;
    compare_all();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] drained [$];
    void'($urandom(32'd20240611));
    req_ie = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 tx_valid", tx_valid, 1'b0);
    chk("R1 tdrq", tdrq, 1'b1);
    chk("R7 irq after reset", irq, 1'b1);

    // R6 single-register behaviour
    cyc(1'b1, 8'hA1, 1'b0);
    chk("R6 write clears flag", tdrq, 1'b0);
    chk("R6 held char", tx_data, 8'hA1);
    cyc(1'b1, 8'hB2, 1'b0);
    chk("R6 overwrite", tx_data, 8'hB2);
    cyc(1'b1, 8'hC3, 1'b1);
    chk("R6 write+pop keeps new", tx_data, 8'hC3);
    chk("R6 write+pop flag", tdrq, 1'b0);
    cyc(1'b0, 8'h00, 1'b1);
    chk("R6 pop sets flag", tdrq, 1'b1);
    req_ie = 1'b0;
    cyc(1'b0, 8'h00, 1'b1);
    chk("R9 pop empty valid", tx_valid, 1'b0);
    chk("R9 pop empty flag", tdrq, 1'b1);
    chk("R7 irq gated", irq, 1'b0);
    req_ie = 1'b1;

    // R8 switch with data held, write in switch cycle ignored
    cyc(1'b1, 8'h5A, 1'b0);
    fifo_mode = 1'b1;
    cyc(1'b1, 8'h77, 1'b0);
    chk("R8 flushed valid", tx_valid, 1'b0);
    chk("R8 flag set", tdrq, 1'b1);

    // R5 threshold and R3 capacity
    for (int i = 0; i < 64; i++) begin
      cyc(1'b1, 8'(i), 1'b0);
      if (i == 31) chk("R5 hold at half from low", tdrq, 1'b1);
      if (i == 32) chk("R5 clear above half", tdrq, 1'b0);
    end
    cyc(1'b1, 8'hEE, 1'b0);
    chk("R3 full head", tx_data, 8'h00);
    // R4 push+pop on full
    cyc(1'b1, 8'hDD, 1'b1);
    chk("R4 head after push+pop", tx_data, 8'h01);
    chk("R4 still valid", tx_valid, 1'b1);
    for (int i = 0; i < 70 && tx_valid; i++) begin
      drained.push_back(tx_data);
      cyc(1'b0, 8'h00, 1'b1);
      if (drained.size() == 32) chk("R5 hold at half from high", tdrq, 1'b0);
      if (drained.size() == 33) chk("R5 set below half", tdrq, 1'b1);
    end
    chk("R3 drained count", drained.size(), 64);
    chk("R4 last is pushed char", drained[drained.size()-1], 8'hDD);
    chk("R2 order mid", drained[10], 8'h0B);
    cyc(1'b0, 8'h00, 1'b1);
    chk("R9 fifo pop empty", tx_valid, 1'b0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      int wp;
      wp = ((i / 400) % 2 == 0) ? 75 : 30;
      if ($urandom_range(0, 399) == 0) fifo_mode = ~fifo_mode;
      if ($urandom_range(0, 19) == 0) req_ie = ~req_ie;
      cyc($urandom_range(0, 99) < wp, 8'($urandom), $urandom_range(0, 99) < (100 - wp));
    end

    // R8 flush from a loaded queue
    fifo_mode = 1'b1;
    cyc(1'b0, 8'h00, 1'b0);
    for (int i = 0; i < 40; i++) cyc(1'b1, 8'(i + 100), 1'b0);
    fifo_mode = 1'b0;
    cyc(1'b0, 8'h00, 1'b1);
    chk("R8 queue flushed", tx_valid, 1'b0);
    chk("R8 flag after flush", tdrq, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule